// File: doc/BRIEF.md
# Word-Level Reconfigurable Array Cell

This block is one processing cell of a coarse-grained array. It works on whole 16-bit words. It holds a functional unit, a four-entry local register file, two operand multiplexers and a store of four configuration contexts. Each context is a 32-bit word that picks the operation, both operand sources, the register addresses, whether the result is written back, whether execution is predicated, and an immediate value. A registered context index chooses the active context, and it may move to a different context on every clock cycle.

New contexts arrive over a narrow load port, one 8-bit quarter per cycle, so a load takes longer than a local context switch. While a load is in flight, the target context cannot be made active. When the cell is lent to the host processor, a mode input hands the functional unit and register file to the processor's own opcode, operands and write controls. In that mode the context index is frozen, so the array and processor uses never overlap in a cycle.

Top module: `rc_cell`

## Requirements
- R1: After reset, `res_q`, `pred_q` and `ld_busy` are 0, the context index is 0 and all four contexts and registers hold 0; context 0 then computes `nbr_a + nbr_a` with no write-back.
- R2: `ctx_sel` is sampled on each clock edge (when no other rule blocks it). The result registered on the following edge comes from the context sampled on the edge before, and a different context may be chosen every cycle.
- R3: Context word layout: op [3:0], A source [5:4], B source [7:6], read address A [9:8], read address B [11:10], write address [13:12], write enable [14], predicate enable [15], immediate [31:16].
- R4: Op codes, 16-bit with wraparound: 0 add, 1 subtract A-B, 2 AND, 3 OR, 4 XOR, 5 shift A left by B[3:0], 6 logical shift A right by B[3:0], 7 pass A. For these ops `pred_q` becomes 0.
- R5: Op 8 compares A==B and op 9 compares A<B unsigned; the flag goes to `pred_q` and `res_q` becomes the flag zero-extended. Codes 10 to 15 act as pass A.
- R6: Operand source codes: 0 `nbr_a`, 1 `nbr_b`, 2 register file (A through read address A, B through read address B), 3 immediate. A register write lands on the same edge as `res_q`, and both read ports can be used in one operation.
- R7: With predicate enable set and `pred_in` low, neither the register file nor `res_q`/`pred_q` change.
- R8: A load starts with `ld_start` high, carrying the target in `ld_idx` and quarter 0 (bits 7:0) in `ld_byte`. Quarters 1, 2 and 3 follow on the next three cycles. `ld_busy` is high for exactly those three cycles, the context is replaced on the fourth edge, and `ld_start` is ignored while busy.
- R9: While `ld_busy` is high, a `ctx_sel` equal to the context being loaded is not taken; the index keeps its previous value.
- R10: With `proc_mode` high the context index holds, `ctx_sel` and `pred_in` are ignored, the op comes from `proc_op` on `proc_a`/`proc_b`, and the write comes from `proc_we`/`proc_wa`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_sel | input | 2 | Requested context index |
| proc_mode | input | 1 | High: cell driven by the processor |
| proc_op | input | 4 | Processor opcode |
| proc_a | input | 16 | Processor operand A |
| proc_b | input | 16 | Processor operand B |
| proc_we | input | 1 | Processor register write enable |
| proc_wa | input | 2 | Processor register write address |
| nbr_a | input | 16 | Neighbour input A |
| nbr_b | input | 16 | Neighbour input B |
| pred_in | input | 1 | Predicate from the array |
| ld_start | input | 1 | Start of a context load |
| ld_idx | input | 2 | Context being loaded |
| ld_byte | input | 8 | Configuration quarter |
| ld_busy | output | 1 | Load in progress |
| res_q | output | 16 | Registered result |
| pred_q | output | 1 | Registered compare flag |

## Verification
The load-port properties assume that `ld_idx` and quarter data follow the four-beat protocol. The bench drives each load from one task that holds that order, so assertions on the busy window and on start suppression see well-formed traffic. The predicate and index properties assume the control inputs change only between edges. Every stimulus is therefore applied on the falling clock edge. Contexts that write back are never chosen to read the register they write, and an idle non-writing context is restored between scenarios so that a held index cannot repeat a write with fresh operands.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int DW   = 16;
  localparam int NCTX = 4;
  localparam int NREG = 4;
  localparam int OPW  = 4;
  localparam int NQ   = 4;
  localparam int CIW  = $clog2(NCTX);
  localparam int AW   = $clog2(NREG);
  localparam int SHW  = $clog2(DW);

  localparam logic [OPW-1:0] OP_ADD = 4'd0;
  localparam logic [OPW-1:0] OP_SUB = 4'd1;
  localparam logic [OPW-1:0] OP_AND = 4'd2;
  localparam logic [OPW-1:0] OP_OR  = 4'd3;
  localparam logic [OPW-1:0] OP_XOR = 4'd4;
  localparam logic [OPW-1:0] OP_SHL = 4'd5;
  localparam logic [OPW-1:0] OP_SHR = 4'd6;
  localparam logic [OPW-1:0] OP_CEQ = 4'd8;
  localparam logic [OPW-1:0] OP_CLT = 4'd9;

  localparam logic [1:0] SRC_NA  = 2'd0;
  localparam logic [1:0] SRC_NB  = 2'd1;
  localparam logic [1:0] SRC_RF  = 2'd2;
  localparam logic [1:0] SRC_IMM = 2'd3;

  typedef struct packed {
    logic [DW-1:0]  imm;
    logic           pen;
    logic           we;
    logic [AW-1:0]  wa;
    logic [AW-1:0]  rb;
    logic [AW-1:0]  ra;
    logic [1:0]     bsel;
    logic [1:0]     asel;
    logic [OPW-1:0] op;
  } cfg_t;

  localparam int CW  = $bits(cfg_t);
  localparam int QW  = CW / NQ;
  localparam int BTW = $clog2(NQ);

  // Returns {flag, result}
  function automatic logic [DW:0] alu_fn(input logic [OPW-1:0] op,
                                         input logic [DW-1:0] a,
                                         input logic [DW-1:0] b);
    logic [DW-1:0] y;
    logic f;
    f = 1'b0;
    case (op)
      OP_ADD: y = a + b;
      OP_SUB: y = a - b;
      OP_AND: y = a & b;
      OP_OR:  y = a | b;
      OP_XOR: y = a ^ b;
      OP_SHL: y = a << b[SHW-1:0];
      OP_SHR: y = a >> b[SHW-1:0];
      OP_CEQ: begin f = (a == b); y = {{(DW-1){1'b0}}, f}; end
      OP_CLT: begin f = (a < b);  y = {{(DW-1){1'b0}}, f}; end
      default: y = a;
    endcase
    return {f, y};
  endfunction
endpackage

// File: rtl/rc_alu.sv
module rc_alu
  import rc_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  output logic [DW-1:0]  y,
  output logic           flag
);
  logic [DW:0] packed_out;
  assign packed_out = alu_fn(op, a, b);
  assign y    = packed_out[DW-1:0];
  assign flag = packed_out[DW];
endmodule

// File: rtl/rc_rf.sv
module rc_rf
  import rc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b
);
  logic [DW-1:0] regs [NREG];
  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    assign hit[g] = we && (wa == AW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)      regs[g] <= '0;
      else if (hit[g]) regs[g] <= wd;
    end
  end

  assign rd_a = regs[ra];
  assign rd_b = regs[rb];

  AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(wa)] == $past(wd)); // R6
endmodule

// File: rtl/rc_cfg_store.sv
module rc_cfg_store
  import rc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_start,
  input  logic [CIW-1:0] ld_idx,
  input  logic [QW-1:0]  ld_byte,
  output logic           busy,
  output logic [CIW-1:0] busy_idx,
  input  logic [CIW-1:0] rd_idx,
  output cfg_t           rd_cfg
);
  localparam logic [BTW-1:0] LAST = BTW'(NQ - 1);

  cfg_t mem [NCTX];
  logic [BTW-1:0] beat_q;
  logic [CIW-1:0] idx_q;
  logic [CW-QW-1:0] shadow_q;
  logic busy_q;
  logic commit;

  assign commit   = busy_q && (beat_q == LAST);
  assign busy     = busy_q;
  assign busy_idx = idx_q;
  assign rd_cfg   = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      beat_q   <= '0;
      idx_q    <= '0;
      shadow_q <= '0;
    end else if (!busy_q) begin
      if (ld_start) begin
        busy_q           <= 1'b1;
        beat_q           <= BTW'(1);
        idx_q            <= ld_idx;
        shadow_q[QW-1:0] <= ld_byte;
      end
    end else if (commit) begin
      busy_q <= 1'b0;
    end else begin
      shadow_q[beat_q*QW +: QW] <= ld_byte;
      beat_q <= beat_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NCTX; g++) begin : g_ctx
    always_ff @(posedge clk) begin
      if (!rst_n)                             mem[g] <= '0;
      else if (commit && idx_q == CIW'(g))    mem[g] <= cfg_t'({ld_byte, shadow_q});
    end
  end

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(ld_start)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ld_start) |=> $stable(idx_q)); // R8
endmodule

// File: rtl/rc_cell.sv
module rc_cell
  import rc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     ctx_sel,
  input  logic           proc_mode,
  input  logic [3:0]     proc_op,
  input  logic [15:0]    proc_a,
  input  logic [15:0]    proc_b,
  input  logic           proc_we,
  input  logic [1:0]     proc_wa,
  input  logic [15:0]    nbr_a,
  input  logic [15:0]    nbr_b,
  input  logic           pred_in,
  input  logic           ld_start,
  input  logic [1:0]     ld_idx,
  input  logic [7:0]     ld_byte,
  output logic           ld_busy,
  output logic [15:0]    res_q,
  output logic           pred_q
);
  logic [CIW-1:0] ctx_q;
  logic [CIW-1:0] busy_idx;
  cfg_t           cfg;
  logic           sel_block;
  logic           exec_en;
  logic [DW-1:0]  rf_a, rf_b, opa, opb, alu_y;
  logic           alu_f;
  logic [OPW-1:0] op_eff;
  logic           rf_we;
  logic [AW-1:0]  rf_wa;

  function automatic logic [DW-1:0] pick(input logic [1:0] s,
                                         input logic [DW-1:0] na,
                                         input logic [DW-1:0] nb,
                                         input logic [DW-1:0] rf,
                                         input logic [DW-1:0] imm);
    case (s)
      SRC_NA:  return na;
      SRC_NB:  return nb;
      SRC_RF:  return rf;
      default: return imm;
    endcase
  endfunction

  rc_cfg_store u_store (
    .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_idx(ld_idx),
    .ld_byte(ld_byte), .busy(ld_busy), .busy_idx(busy_idx),
    .rd_idx(ctx_q), .rd_cfg(cfg)
  );

  assign sel_block = ld_busy && (ctx_sel == busy_idx);

  always_ff @(posedge clk) begin
    if (!rst_n)                        ctx_q <= '0;
    else if (!proc_mode && !sel_block) ctx_q <= ctx_sel;
  end

  assign opa     = proc_mode ? proc_a  : pick(cfg.asel, nbr_a, nbr_b, rf_a, cfg.imm);
  assign opb     = proc_mode ? proc_b  : pick(cfg.bsel, nbr_a, nbr_b, rf_b, cfg.imm);
  assign op_eff  = proc_mode ? proc_op : cfg.op;
  assign exec_en = proc_mode || !cfg.pen || pred_in;
  assign rf_we   = proc_mode ? proc_we : (cfg.we && exec_en);
  assign rf_wa   = proc_mode ? proc_wa : cfg.wa;

  rc_alu u_alu (.op(op_eff), .a(opa), .b(opb), .y(alu_y), .flag(alu_f));

  rc_rf u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .wa(rf_wa), .wd(alu_y),
    .ra(cfg.ra), .rb(cfg.rb), .rd_a(rf_a), .rd_b(rf_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q  <= '0;
      pred_q <= 1'b0;
    end else if (exec_en) begin
      res_q  <= alu_y;
      pred_q <= alu_f;
    end
  end

  AST_CTX_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    proc_mode |=> ctx_q == $past(ctx_q)); // R10
  AST_CTX_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_mode && sel_block) |=> ctx_q == $past(ctx_q)); // R9
  AST_CTX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_mode && !ld_busy) |=> ctx_q == $past(ctx_sel)); // R2
  AST_PRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_mode && cfg.pen && !pred_in) |=> ($stable(res_q) && $stable(pred_q))); // R7
endmodule

// File: tb/sim_rc_cell.sv
module sim_rc_cell;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ctx_sel = '0;
  logic        proc_mode = 1'b0;
  logic [3:0]  proc_op = '0;
  logic [15:0] proc_a = '0, proc_b = '0;
  logic        proc_we = 1'b0;
  logic [1:0]  proc_wa = '0;
  logic [15:0] nbr_a = '0, nbr_b = '0;
  logic        pred_in = 1'b1;
  logic        ld_start = 1'b0;
  logic [1:0]  ld_idx = '0;
  logic [7:0]  ld_byte = '0;
  logic        ld_busy;
  logic [15:0] res_q;
  logic        pred_q;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] got_res;
  logic        got_pred;

  always #10 clk = ~clk;

  rc_cell u0 (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int op, input int as, input int bs, input int ra,
                                      input int rb, input int wa, input bit we, input bit pen,
                                      input logic [15:0] imm);
    logic [31:0] w;
    w = {imm, pen, we, wa[1:0], rb[1:0], ra[1:0], bs[1:0], as[1:0], op[3:0]};
    return w;
  endfunction

  // Independent model: {flag, result}
  function automatic logic [16:0] model(input int op, input logic [15:0] a, input logic [15:0] b);
    int sh;
    sh = int'(b & 16'h000F);
    if (op == 0) return {1'b0, 16'(a + b)};
    if (op == 1) return {1'b0, 16'(a + ~b + 16'd1)};
    if (op == 2) return {1'b0, a & b};
    if (op == 3) return {1'b0, a | b};
    if (op == 4) return {1'b0, a ^ b};
    if (op == 5) return {1'b0, 16'(a * (17'd1 << sh))};
    if (op == 6) return {1'b0, 16'(a / (17'd1 << sh))};
    if (op == 8) return (a == b) ? 17'h10001 : 17'h0;
    if (op == 9) return (a < b)  ? 17'h10001 : 17'h0;
    return {1'b0, a};
  endfunction

  task automatic load_ctx(input logic [1:0] idx, input logic [31:0] w, input bit noise);
    @(negedge clk);
    ld_start = 1'b1; ld_idx = idx; ld_byte = w[7:0];
    @(posedge clk);
    for (int q = 1; q < 4; q++) begin
      @(negedge clk);
      if (q == 1) check(ld_busy === 1'b1, "R8 busy after start", ld_busy, 1);
      ld_start = noise; ld_idx = noise ? idx ^ 2'd2 : idx; ld_byte = w[q*8 +: 8];
      @(posedge clk);
    end
    @(negedge clk);
    check(ld_busy === 1'b0, "R8 busy clear after fourth quarter", ld_busy, 0);
    ld_start = 1'b0; ld_idx = '0; ld_byte = '0;
  endtask

  // Select a context, apply operands, capture result, return to idle context 0
  task automatic exec1(input logic [1:0] c, input logic [15:0] a, input logic [15:0] b, input bit p);
    @(negedge clk);
    ctx_sel = c; nbr_a = a; nbr_b = b; pred_in = p;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    got_res = res_q; got_pred = pred_q;
    ctx_sel = 2'd0;
    @(posedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(res_q === 16'h0, "R1 res_q reset", res_q, 0);
    check(pred_q === 1'b0, "R1 pred_q reset", pred_q, 0);
    check(ld_busy === 1'b0, "R1 ld_busy reset", ld_busy, 0);
    exec1(2'd0, 16'd5, 16'd9, 1'b1);
    check(got_res === 16'd10, "R1 context 0 adds nbr_a twice", got_res, 10);
  endtask

  task automatic t_ops;
    logic [15:0] av [3] = '{16'h8001, 16'h1234, 16'h0005};
    logic [15:0] bv [3] = '{16'h0003, 16'h1234, 16'hFFF0};
    for (int op = 0; op < 16; op++) begin
      load_ctx(2'd2, mk(op, 0, 1, 0, 0, 0, 0, 0, 16'h0), 1'b0);
      for (int k = 0; k < 3; k++) begin
        logic [16:0] e;
        e = model(op, av[k], bv[k]);
        exec1(2'd2, av[k], bv[k], 1'b1);
        if (op == 8 || op == 9) begin
          check(got_res === e[15:0], "R5 compare result", got_res, e[15:0]);
          check(got_pred === e[16], "R5 compare flag", got_pred, e[16]);
        end else begin
          check(got_res === e[15:0], "R4 op result", got_res, e[15:0]);
          check(got_pred === 1'b0, "R4 flag cleared", got_pred, 0);
        end
      end
    end
    load_ctx(2'd2, mk(7, 1, 0, 0, 0, 0, 0, 0, 16'h0), 1'b0);
    exec1(2'd2, 16'h1111, 16'h2222, 1'b1);
    check(got_res === 16'h2222, "R6 source code 1 selects nbr_b", got_res, 16'h2222);
  endtask

  task automatic t_pred_rf;
    load_ctx(2'd1, mk(0, 0, 3, 0, 0, 1, 1, 1, 16'h0100), 1'b1);
    load_ctx(2'd3, mk(7, 2, 0, 1, 0, 0, 0, 0, 16'h0), 1'b0);
    exec1(2'd1, 16'h0042, 16'h0, 1'b0);
    check(got_res === 16'h0084, "R7 blocked result holds", got_res, 16'h0084);
    exec1(2'd3, 16'h0, 16'h0, 1'b0);
    check(got_res === 16'h0000, "R7 blocked write leaves register", got_res, 0);
    exec1(2'd1, 16'h0042, 16'h0, 1'b1);
    check(got_res === 16'h0142, "R3 R8 loaded immediate add", got_res, 16'h0142);
    exec1(2'd3, 16'h0, 16'h0, 1'b1);
    check(got_res === 16'h0142, "R6 register written and read", got_res, 16'h0142);
  endtask

  task automatic t_switch;
    logic [1:0] s [8] = '{0, 2, 3, 2, 0, 3, 3, 2};
    logic [15:0] f [4];
    load_ctx(2'd2, mk(4, 0, 1, 0, 0, 0, 0, 0, 16'h0), 1'b0);
    load_ctx(2'd3, mk(7, 3, 0, 0, 0, 0, 0, 0, 16'hBEEF), 1'b0);
    f[0] = 16'h01E0; f[2] = 16'h0FFF; f[3] = 16'hBEEF; f[1] = 16'h0;
    @(negedge clk);
    nbr_a = 16'h00F0; nbr_b = 16'h0F0F; pred_in = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i >= 2) check(res_q === f[s[i-2]], "R2 per-cycle context switch", res_q, f[s[i-2]]);
      ctx_sel = (i < 8) ? s[i] : 2'd0;
      @(posedge clk);
    end
  endtask

  task automatic t_lock;
    logic [31:0] w;
    w = mk(1, 0, 1, 0, 0, 0, 0, 0, 16'h0);
    @(negedge clk);
    ctx_sel = 2'd0; ld_start = 1'b1; ld_idx = 2'd2; ld_byte = w[7:0];
    @(posedge clk);
    @(negedge clk);
    ld_start = 1'b0; ld_byte = w[15:8]; ctx_sel = 2'd2;
    @(posedge clk);
    @(negedge clk);
    ld_byte = w[23:16];
    @(posedge clk);
    @(negedge clk);
    check(res_q === 16'h01E0, "R9 loading context not selectable", res_q, 16'h01E0);
    ld_byte = w[31:24];
    @(posedge clk);
    @(negedge clk);
    check(ld_busy === 1'b0, "R8 busy drops at commit", ld_busy, 0);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(res_q === 16'hF1E1, "R9 selectable after load", res_q, 16'hF1E1);
    ctx_sel = 2'd0;
    @(posedge clk);
  endtask

  task automatic t_proc;
    load_ctx(2'd3, mk(7, 2, 0, 1, 0, 0, 0, 0, 16'h0), 1'b0);
    @(negedge clk);
    proc_mode = 1'b1; proc_op = 4'd0; proc_a = 16'h1111; proc_b = 16'h0222;
    proc_we = 1'b1; proc_wa = 2'd2; ctx_sel = 2'd3; pred_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(res_q === 16'h1333, "R10 processor op result", res_q, 16'h1333);
    proc_mode = 1'b0; proc_we = 1'b0; ctx_sel = 2'd0; nbr_a = 16'd7; pred_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(res_q === 16'd14, "R10 context index frozen in processor mode", res_q, 14);
    load_ctx(2'd3, mk(1, 2, 2, 1, 2, 0, 0, 0, 16'h0), 1'b0);
    exec1(2'd3, 16'h0, 16'h0, 1'b1);
    check(got_res === 16'hEE0F, "R6 R10 dual read of processor write", got_res, 16'hEE0F);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ops();
    t_pred_rf();
    t_switch();
    t_lock();
    t_proc();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule